// File: doc/BRIEF.md
# MII Receive Frame Status Monitor

This block sits beside a media-independent receive path and observes the four-bit receive stream from the PHY, together with the data-valid, error and collision lines. It does not store the frame. It finds the start-of-frame delimiter, packs the nibbles into bytes and counts them. From these bytes it checks the frame check sequence, classifies the length/type field, and applies a byte-count watchdog that cuts off an overlong frame. It also collects the receive-error, odd-nibble and late-collision conditions, each under its own validity rule.

When a frame ends, or when the watchdog cuts it off, the block presents a six-bit status word and the frame's byte count together with a one-cycle valid strobe. A duplex-mode input decides whether a collision can be reported at all. A limit-select input chooses between the short and the long watchdog limit.

Top module: `mii_rx_status_mon`

## Requirements
- R1: Data bytes start only after a nibble 0x5 is directly followed by a nibble 0xD while `rx_dv` is high. A data-valid period without that pair produces no status strobe.
- R2: `stat_valid` is high for exactly one cycle, in the cycle after the clock edge that samples `rx_dv` low at the end of a frame. `stat_len` then holds the number of complete bytes after the delimiter, FCS included.
- R3: `stat_flags[0]` (CRC error) is set when the reflected CRC-32 (polynomial 0xEDB88320 in reflected form, start value 0xFFFFFFFF, low nibble of each byte first) over all complete bytes, FCS included, does not leave the register at 0xDEBB20E3.
- R4: `stat_flags[4]` (type frame) is set when the 16-bit length/type field is 0x0600 or above, and clear below 0x0600. Byte 12 after the delimiter is the high half of this field and byte 13 is the low half.
- R5: For frames of fewer than 14 bytes, `stat_flags[4]` is 0 whatever the bytes hold.
- R6: With `wd_long_sel` = 0, byte number 2049 cuts the frame off. The strobe comes in the cycle after its second nibble is sampled, with `stat_flags[3]` = 1, `stat_len` = 2049, `stat_flags[0]` = 1 and `stat_flags[1]` = 0. The rest of the frame is ignored and gives no second strobe. A 2048-byte frame does not set `stat_flags[3]`.
- R7: With `wd_long_sel` = 1, the cut-off limit is 16384 bytes instead, and a frame of 16385 bytes or more is cut off at byte 16385 in the same way as in R6.
- R8: `stat_flags[2]` (receive error) is set if `rx_er` is high in any cycle in which `rx_dv` is high, from the first data-valid cycle of the frame (preamble included) up to the report. `rx_er` while `rx_dv` is low has no effect.
- R9: `stat_flags[1]` (dribble) is set when an odd number of nibbles follows the delimiter. The trailing nibble counts neither in `stat_len` nor in the CRC.
- R10: `stat_flags[5]` (late collision) is set when `half_duplex` = 1 and `col` is high in a data cycle in which at least 64 bytes are already complete. A collision seen earlier in the frame, or seen with `half_duplex` = 0, is ignored.
- R11: After reset, `stat_valid`, `stat_flags` and `stat_len` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error from the PHY |
| rxd | input | 4 | Receive nibble |
| col | input | 1 | Collision indication |
| half_duplex | input | 1 | 1: half duplex, collisions can be reported |
| wd_long_sel | input | 1 | Watchdog limit select: 0 short, 1 long |
| stat_valid | output | 1 | One-cycle status strobe |
| stat_flags | output | 6 | [0] CRC error, [1] dribble, [2] receive error, [3] watchdog cut-off, [4] type frame, [5] late collision |
| stat_len | output | LEN_W (15) | Complete bytes received |

## Verification
The hardest state to reach is the long watchdog cut-off. It needs a single frame of more than 16384 bytes, with the cut-off strobe landing on one exact nibble while the line stays busy afterwards. The bench generates frame bytes arithmetically from their index and computes the FCS on the fly. Because no storage is needed, frames on either side of both limits are sent whole. The bench records the cycle in which the deciding nibble was driven and compares it with the cycle of the strobe. The late-collision threshold is handled the same way: the collision is placed on the first nibble of byte 63 or of byte 64, so that exactly 63 or 64 bytes are complete when it is seen.

// File: rtl/mrs_pkg.sv
`timescale 1ns/1ps
package mrs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PRE,
      ST_DATA,
      ST_DROP
   } mrs_state_e;

   localparam int unsigned FLAG_W = 6;
   localparam int unsigned F_CRC  = 0;
   localparam int unsigned F_DRIB = 1;
   localparam int unsigned F_RXER = 2;
   localparam int unsigned F_WDOG = 3;
   localparam int unsigned F_TYPE = 4;
   localparam int unsigned F_LCOL = 5;

   localparam logic [3:0]  PRE_NIB    = 4'h5;
   localparam logic [3:0]  SFD_NIB    = 4'hD;
   localparam logic [15:0] TYPE_MIN   = 16'h0600;
   localparam int unsigned TYPE_OFS   = 12;
   localparam int unsigned RUNT_BYTES = TYPE_OFS + 2;

   localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
   localparam logic [31:0] CRC_SEED    = 32'hFFFFFFFF;
   localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

   function automatic logic [31:0] crc_fold_byte(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int k = 0; k < 8; k++)
         r = (r[0] ^ d[k]) ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
      return r;
   endfunction

endpackage

// File: rtl/mrs_nibble_packer.sv
`timescale 1ns/1ps
module mrs_nibble_packer (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       nib_en,
   input  logic [3:0] nib,
   output logic       odd_nib,
   output logic       byte_stb,
   output logic [7:0] byte_val
);
   logic [3:0] low_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         odd_nib <= 1'b0;
         low_q   <= '0;
      end else if (nib_en) begin
         odd_nib <= ~odd_nib;
         if (!odd_nib) low_q <= nib;
      end
   end

   assign byte_stb = nib_en & odd_nib;
   assign byte_val = {nib, low_q};
endmodule

// File: rtl/mrs_crc_acc.sv
`timescale 1ns/1ps
module mrs_crc_acc
   import mrs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       byte_stb,
   input  logic [7:0] byte_val,
   output logic       crc_ok
);
   logic [31:0] crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear)
         crc_q <= CRC_SEED;
      else if (byte_stb)
         crc_q <= crc_fold_byte(crc_q, byte_val);
   end

   assign crc_ok = (crc_q == CRC_RESIDUE);
endmodule

// File: rtl/mrs_byte_counter.sv
`timescale 1ns/1ps
module mrs_byte_counter #(
   parameter int unsigned WD_SHORT  = 2048,
   parameter int unsigned WD_LONG   = 16384,
   parameter int unsigned LATE_BYTES = 64,
   parameter int unsigned LEN_W     = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             byte_stb,
   input  logic             wd_long_sel,
   output logic [LEN_W-1:0] count,
   output logic             expire,
   output logic             late_zone
);
   logic [LEN_W-1:0] limit;

   generate
      if (WD_SHORT == WD_LONG) begin : g_one_limit
         assign limit = LEN_W'(WD_SHORT);
      end else begin : g_two_limits
         assign limit = wd_long_sel ? LEN_W'(WD_LONG) : LEN_W'(WD_SHORT);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clear)
         count <= '0;
      else if (byte_stb)
         count <= count + LEN_W'(1);
   end

   assign expire    = byte_stb && (count >= limit);
   assign late_zone = (count >= LEN_W'(LATE_BYTES));

   logic unused_sel;
   assign unused_sel = wd_long_sel;
endmodule

// File: rtl/mii_rx_status_mon.sv
`timescale 1ns/1ps
module mii_rx_status_mon
   import mrs_pkg::*;
#(
   parameter  int unsigned WD_SHORT   = 2048,
   parameter  int unsigned WD_LONG    = 16384,
   parameter  int unsigned LATE_BYTES = 64,
   localparam int unsigned LEN_W      = $clog2(WD_LONG + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_dv,
   input  logic              rx_er,
   input  logic [3:0]        rxd,
   input  logic              col,
   input  logic              half_duplex,
   input  logic              wd_long_sel,
   output logic              stat_valid,
   output logic [FLAG_W-1:0] stat_flags,
   output logic [LEN_W-1:0]  stat_len
);
   generate
      if (WD_LONG < WD_SHORT) begin : g_bad_order
         $error("WD_LONG must not be below WD_SHORT");
      end
      if (WD_SHORT < RUNT_BYTES) begin : g_bad_short
         $error("WD_SHORT must cover the length/type field");
      end
      if (LATE_BYTES == 0) begin : g_bad_late
         $error("LATE_BYTES must be nonzero");
      end
   endgenerate

   mrs_state_e        state;
   logic [3:0]        prev_nib;
   logic              er_seen, col_seen;
   logic [7:0]        lt_hi, lt_lo;
   logic              in_data, nib_en, clr_frame;
   logic              odd_nib, byte_stb, crc_ok, wd_expire, late_zone;
   logic [7:0]        byte_val;
   logic [LEN_W-1:0]  byte_cnt;
   logic              er_nxt, col_nxt, type_hit;
   logic              rep_go;
   logic [FLAG_W-1:0] rep_flags;
   logic [LEN_W-1:0]  rep_len;

   assign in_data   = (state == ST_DATA);
   assign nib_en    = in_data & rx_dv;
   assign clr_frame = ~in_data;

   mrs_nibble_packer u_pack (
      .clk(clk), .rst_n(rst_n), .clear(clr_frame), .nib_en(nib_en), .nib(rxd),
      .odd_nib(odd_nib), .byte_stb(byte_stb), .byte_val(byte_val)
   );

   mrs_crc_acc u_crc (
      .clk(clk), .rst_n(rst_n), .clear(clr_frame), .byte_stb(byte_stb),
      .byte_val(byte_val), .crc_ok(crc_ok)
   );

   mrs_byte_counter #(
      .WD_SHORT(WD_SHORT), .WD_LONG(WD_LONG), .LATE_BYTES(LATE_BYTES), .LEN_W(LEN_W)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .clear(clr_frame), .byte_stb(byte_stb),
      .wd_long_sel(wd_long_sel), .count(byte_cnt), .expire(wd_expire),
      .late_zone(late_zone)
   );

   assign er_nxt   = er_seen | (rx_dv & rx_er);
   assign col_nxt  = col_seen | (half_duplex & col & nib_en & late_zone);
   assign type_hit = ({lt_hi, lt_lo} >= TYPE_MIN);

   always_comb begin
      rep_go    = 1'b0;
      rep_flags = '0;
      rep_len   = byte_cnt;
      if (in_data) begin
         if (!rx_dv) begin
            rep_go            = 1'b1;
            rep_flags[F_CRC]  = ~crc_ok;
            rep_flags[F_DRIB] = odd_nib;
            rep_flags[F_TYPE] = (byte_cnt >= LEN_W'(RUNT_BYTES)) & type_hit;
         end else if (wd_expire) begin
            rep_go            = 1'b1;
            rep_len           = byte_cnt + LEN_W'(1);
            rep_flags[F_CRC]  = 1'b1;
            rep_flags[F_WDOG] = 1'b1;
            rep_flags[F_TYPE] = type_hit;
         end
         rep_flags[F_RXER] = er_nxt;
         rep_flags[F_LCOL] = col_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         prev_nib   <= '0;
         er_seen    <= 1'b0;
         col_seen   <= 1'b0;
         lt_hi      <= '0;
         lt_lo      <= '0;
         stat_valid <= 1'b0;
         stat_flags <= '0;
         stat_len   <= '0;
      end else begin
         stat_valid <= rep_go;
         if (rep_go) begin
            stat_flags <= rep_flags;
            stat_len   <= rep_len;
         end
         if (byte_stb && byte_cnt == LEN_W'(TYPE_OFS))     lt_hi <= byte_val;
         if (byte_stb && byte_cnt == LEN_W'(TYPE_OFS + 1)) lt_lo <= byte_val;
         case (state)
            ST_IDLE: if (rx_dv) begin
               state    <= ST_PRE;
               prev_nib <= rxd;
               er_seen  <= rx_er;
               col_seen <= 1'b0;
            end
            ST_PRE: if (!rx_dv) begin
               state <= ST_IDLE;
            end else begin
               er_seen  <= er_nxt;
               prev_nib <= rxd;
               if (prev_nib == PRE_NIB && rxd == SFD_NIB) state <= ST_DATA;
            end
            ST_DATA: begin
               er_seen  <= er_nxt;
               col_seen <= col_nxt;
               if (!rx_dv)         state <= ST_IDLE;
               else if (wd_expire) state <= ST_DROP;
            end
            default: if (!rx_dv) state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mrs_checker.sv
`timescale 1ns/1ps
module mrs_checker
   import mrs_pkg::*;
#(
   parameter int unsigned WD_SHORT   = 2048,
   parameter int unsigned WD_LONG    = 16384,
   parameter int unsigned LATE_BYTES = 64,
   parameter int unsigned LEN_W      = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_dv,
   input logic              in_data,
   input logic              stat_valid,
   input logic [FLAG_W-1:0] stat_flags,
   input logic [LEN_W-1:0]  stat_len
);
   // R1
   report_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |-> $past(in_data));

   // R2
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |=> !stat_valid);

   // R2
   end_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data && !rx_dv) |=> stat_valid);

   // R5
   runt_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_len < LEN_W'(RUNT_BYTES)) |-> !stat_flags[F_TYPE]);

   // R6
   cut_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_flags[F_WDOG]) |->
         (stat_flags[F_CRC] && !stat_flags[F_DRIB] &&
          (stat_len == LEN_W'(WD_SHORT + 1) || stat_len == LEN_W'(WD_LONG + 1))));

   // R7
   len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |-> (stat_len <= LEN_W'(WD_LONG + 1)));

   // R10
   early_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_len < LEN_W'(LATE_BYTES)) |-> !stat_flags[F_LCOL]);
endmodule

bind mii_rx_status_mon mrs_checker #(
   .WD_SHORT(WD_SHORT), .WD_LONG(WD_LONG), .LATE_BYTES(LATE_BYTES), .LEN_W(LEN_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .in_data(in_data),
   .stat_valid(stat_valid), .stat_flags(stat_flags), .stat_len(stat_len)
);

// File: tb/mii_rx_status_mon_test.sv
`timescale 1ns/1ps
module mii_rx_status_mon_test;
   localparam int LW = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_dv = 1'b0, rx_er = 1'b0, col = 1'b0;
   logic [3:0] rxd = '0;
   logic half_duplex = 1'b1, wd_long_sel = 1'b0;
   logic stat_valid;
   logic [5:0] stat_flags;
   logic [LW-1:0] stat_len;

   int n_chk = 0, n_bad = 0, cyc = 0;
   int n_pulse = 0, m_cyc = 0;
   logic [5:0] m_flags = '0;
   logic [LW-1:0] m_len = '0;
   bit done = 0;

   always #2.5 clk = ~clk;

   mii_rx_status_mon uut (
      .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd), .col(col),
      .half_duplex(half_duplex), .wd_long_sel(wd_long_sel),
      .stat_valid(stat_valid), .stat_flags(stat_flags), .stat_len(stat_len)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk)
      if (stat_valid) begin
         n_pulse = n_pulse + 1;
         m_flags = stat_flags;
         m_len   = stat_len;
         m_cyc   = cyc;
      end

   task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", what, got, exp);
      end
   endtask

   function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r = c;
      logic [7:0] x = d;
      for (int k = 0; k < 8; k++) begin
         if ((r[0] ^ x[0]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
         else r = r >> 1;
         x = x >> 1;
      end
      return r;
   endfunction

   task automatic drive(input logic [3:0] d, input bit er, input bit c);
      @(negedge clk);
      rx_dv = 1'b1; rxd = d; rx_er = er; col = c;
   endtask

   task automatic run_frame(input int nbytes, input logic [15:0] lt, input bit fcs,
                            input bit corrupt, input bit drib, input int er_nib,
                            input bit er_idle, input int col_byte, input bit hd,
                            input bit wsel, input string tag);
      int limit = wsel ? 16384 : 2048;
      int total = nbytes + (fcs ? 4 : 0);
      bit cut = total > limit;
      logic [31:0] c = 32'hFFFFFFFF;
      logic [31:0] fc = '0;
      logic [7:0] b;
      int nib_i = 0, cut_cyc = 0, end_cyc, p0, elen;
      bit er_hit = 0;
      logic [5:0] ef;
      half_duplex = hd; wd_long_sel = wsel;
      repeat (4) begin
         @(negedge clk);
         rx_dv = 1'b0; rx_er = er_idle; col = 1'b0; rxd = 4'h5;
      end
      p0 = n_pulse;
      for (int k = 0; k < 16; k++) begin
         drive((k == 15) ? 4'hD : 4'h5, nib_i == er_nib, 1'b0);
         if (nib_i == er_nib) er_hit = 1;
         nib_i++;
      end
      for (int i = 0; i < total; i++) begin
         if (i < nbytes)
            b = (i == 12) ? lt[15:8] : (i == 13) ? lt[7:0] : 8'(i * 37 + nbytes);
         else begin
            if (i == nbytes) fc = ~c;
            b = fc[8*(i-nbytes) +: 8];
            if (corrupt && i == nbytes) b = b ^ 8'h01;
         end
         c = crc_step(c, b);
         drive(b[3:0], nib_i == er_nib, i == col_byte);
         if (nib_i == er_nib && !(cut && i > limit)) er_hit = 1;
         nib_i++;
         drive(b[7:4], nib_i == er_nib, 1'b0);
         if (nib_i == er_nib && !(cut && i >= limit)) er_hit = 1;
         if (cut && i == limit) cut_cyc = cyc;
         nib_i++;
      end
      if (drib) drive(4'hA, 1'b0, 1'b0);
      @(negedge clk);
      rx_dv = 1'b0; rx_er = 1'b0; col = 1'b0;
      end_cyc = cyc;
      @(negedge clk); #1;
      ef = '0;
      if (cut) begin
         elen = limit + 1;
         ef[0] = 1'b1; ef[3] = 1'b1;
         ef[5] = hd && col_byte >= 64 && col_byte <= limit;
      end else begin
         elen = total;
         ef[0] = (c != 32'hDEBB20E3);
         ef[1] = drib;
         ef[5] = hd && col_byte >= 64 && col_byte < total;
      end
      ef[2] = er_hit;
      ef[4] = (elen >= 14) && (lt >= 16'h0600);
      chk({tag, " R2 strobe count"}, n_pulse - p0, 1);
      chk({tag, " R2 strobe cycle"}, m_cyc, cut ? cut_cyc + 1 : end_cyc + 1);
      chk({tag, " R2 length"}, 32'(m_len), elen);
      chk({tag, " R3 crc flag"}, 32'(m_flags[0]), 32'(ef[0]));
      chk({tag, " R9 dribble flag"}, 32'(m_flags[1]), 32'(ef[1]));
      chk({tag, " R8 rx error flag"}, 32'(m_flags[2]), 32'(ef[2]));
      chk({tag, " R6 R7 watchdog flag"}, 32'(m_flags[3]), 32'(ef[3]));
      chk({tag, " R4 R5 type flag"}, 32'(m_flags[4]), 32'(ef[4]));
      chk({tag, " R10 late collision flag"}, 32'(m_flags[5]), 32'(ef[5]));
      @(negedge clk); #1;
      chk({tag, " R2 strobe width"}, 32'(stat_valid), 0);
   endtask

   task automatic raw_burst(input int n5, input bit bad_pair);
      int p0 = n_pulse;
      for (int k = 0; k < n5; k++) drive(4'h5, 1'b0, 1'b0);
      if (bad_pair) begin
         drive(4'hA, 1'b0, 1'b0); drive(4'hD, 1'b0, 1'b0); drive(4'h3, 1'b0, 1'b0);
      end
      @(negedge clk); rx_dv = 1'b0;
      repeat (3) @(negedge clk);
      #1 chk("R1 no status without delimiter", n_pulse - p0, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      #1;
      chk("R11 reset valid", 32'(stat_valid), 0);
      chk("R11 reset flags", 32'(stat_flags), 0);
      chk("R11 reset length", 32'(stat_len), 0);
      @(negedge clk); rst_n = 1'b1;

      // R3 R4: sweep of clean frames over lengths and type values
      for (int n = 14; n <= 74; n += 4) begin
         run_frame(n, 16'h0800, 1, 0, 0, -1, 0, -1, 1, 0, "clean");
         run_frame(n, 16'h05FF, 1, 0, 0, -1, 0, -1, 1, 0, "len05ff");
         run_frame(n, 16'h0600, 1, 0, 0, -1, 0, -1, 1, 0, "len0600");
         run_frame(n, 16'h002E, 1, 0, 0, -1, 0, -1, 1, 0, "len002e");
      end
      // R5: runts with a type-like field, no FCS
      for (int n = 0; n <= 15; n++)
         run_frame(n, 16'h8100, 0, 0, 0, -1, 0, -1, 1, 0, "runt");
      // R3: corrupted FCS
      for (int n = 14; n <= 60; n += 23)
         run_frame(n, 16'h0800, 1, 1, 0, -1, 0, -1, 1, 0, "badfcs");
      // R9: odd trailing nibble
      run_frame(20, 16'h0800, 1, 0, 1, -1, 0, -1, 1, 0, "dribble20");
      run_frame(33, 16'h0400, 1, 0, 1, -1, 0, -1, 1, 0, "dribble33");
      // R8: receive error in preamble, in data, and only while idle
      run_frame(40, 16'h0800, 1, 0, 0, 3, 0, -1, 1, 0, "er_pre");
      run_frame(40, 16'h0800, 1, 0, 0, 57, 0, -1, 1, 0, "er_data");
      run_frame(40, 16'h0800, 1, 0, 0, -1, 1, -1, 1, 0, "er_idle");
      // R10: collision thresholds and duplex gating
      run_frame(120, 16'h0800, 1, 0, 0, -1, 0, 63, 1, 0, "col63");
      run_frame(120, 16'h0800, 1, 0, 0, -1, 0, 64, 1, 0, "col64");
      run_frame(120, 16'h0800, 1, 0, 0, -1, 0, 100, 1, 0, "col100");
      run_frame(120, 16'h0800, 1, 0, 0, -1, 0, 100, 0, 0, "col_fd");
      run_frame(120, 16'h0800, 1, 0, 0, -1, 0, 10, 1, 0, "col10");
      // R1: data-valid without a delimiter
      raw_burst(10, 0);
      raw_burst(6, 1);
      // R6: short watchdog limit
      run_frame(2044, 16'h0800, 1, 0, 0, -1, 0, -1, 1, 0, "wd2048");
      run_frame(2045, 16'h0800, 1, 0, 0, 4000, 0, 1000, 1, 0, "wd2049");
      run_frame(2100, 16'h0800, 1, 0, 0, 4150, 0, 2060, 1, 0, "wd_tail");
      // R7: long watchdog limit
      run_frame(2045, 16'h0800, 1, 0, 0, -1, 0, -1, 1, 1, "wdl2049");
      run_frame(16380, 16'h0800, 1, 0, 0, -1, 0, -1, 1, 1, "wdl16384");
      run_frame(16381, 16'h0800, 1, 0, 0, -1, 0, -1, 1, 1, "wdl16385");
      // R1: status path still live after the cut-off frames
      run_frame(30, 16'h0800, 1, 0, 0, -1, 0, -1, 1, 0, "after");

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule